// File: doc/BRIEF.md
# Sized ALU with Packed Condition Flags

This block performs one arithmetic or logical operation per accepted transfer on operands of 8, 16 or 32 bits, and produces a size-masked result, a write-back enable and a new 4-bit flag word. The caller supplies a destination operand, a source operand, a size code, an operation code and the current flag word. Additions and subtractions, with or without the incoming carry, are supported, as are compare, negate, step up or down by one or two, and bitwise AND, OR and XOR. Three further operations apply AND, OR or XOR of an immediate directly to the flag word.

Operations enter on a valid/ready input channel and leave through a single registered output stage on a valid/ready output channel. The input channel accepts a transfer whenever the output register is empty or is being drained in the same cycle. A held output (valid high, ready low) keeps its result, store bit and flags unchanged and blocks the input. There is no buffering beyond that one register, so full throughput needs `out_ready` held high.

Top module: `flagalu`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The flag word is packed N=bit 3, Z=bit 2, V=bit 1, C=bit 0. For every operation that forms a data result, the result is masked to the operand size (size code 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits; bits above it are 0), N is the result's top bit at that size and Z is 1 exactly when the masked result is 0.
- R3: Operation code 0 (add) stores dst+src. C is the carry out of the selected size, and V is set when the signed sum does not fit that size.
- R4: Operation code 1 (add with carry) always works on 8 bits whatever the size code, stores dst+src+C_in, and sets C and V as in R3.
- R5: Operation code 2 (subtract) stores dst-src. C is 1 when src is larger than dst as unsigned numbers, and V is set when the signed difference does not fit the size.
- R6: Operation code 3 (subtract with carry) always works on 8 bits, stores dst-src-C_in, and sets C when src+C_in exceeds dst unsigned, with V as in R5.
- R7: Operation code 4 (compare) produces the flags of R5 but drives the store enable to 0.
- R8: Operation code 5 (negate) stores 0-dst at the size. V is 1 only when dst is the most negative value of the size, and C is 1 when dst is nonzero.
- R9: Operation codes 6/7 add 1/2 to dst and 8/9 subtract 1/2 from dst. N and Z follow R2, V is set when the signed result wraps past the positive maximum or the negative minimum, and C keeps its incoming value.
- R10: Operation codes 10/11/12 store dst AND/OR/XOR src. They clear V and keep the incoming C.
- R11: Operation codes 13/14/15 set the new flag word to the incoming flag word AND/OR/XOR src[3:0]. The result is 0 and the store enable is 0.
- R12: `in_ready` equals NOT `out_valid` OR `out_ready`. An accepted input appears on the outputs one cycle later. While `out_valid` is 1 and `out_ready` is 0, the output fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken this cycle |
| in_op | input | 4 | Operation code (0..15, see requirements) |
| in_size | input | 2 | Operand size code: 0 = 8, 1 = 16, 2/3 = 32 bits |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Source operand or immediate |
| in_flags | input | 4 | Current flag word {N,Z,V,C} |
| out_valid | output | 1 | Output holds a completed operation |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_result | output | 32 | Size-masked result |
| out_store | output | 1 | Result should be written back |
| out_flags | output | 4 | New flag word {N,Z,V,C} |

## Verification
At 8 bits every destination value is paired with a set of source values at the unsigned and signed boundaries (0, 1, 0x7F, 0x80, 0xFF and their neighbours), under every operation code. The destination carries nonzero upper bits so that any leak past the size mask shows up. The 16- and 32-bit sweeps cross the same boundary classes with both incoming carry values, which separates carry-out from overflow, borrow from sign change, and the forced 8-bit width of the carry operations from the requested size. A stall sequence holds `out_ready` low with a new transfer waiting. It tells a correctly held output register apart from one that overwrites or drops data.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 4;
  localparam int OP_W   = 4;
  localparam int SIZE_W = 2;
  localparam int BYTE_W = DATA_W / 4;
  localparam int HALF_W = DATA_W / 2;

  // flag bit positions inside the packed flag word
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_INC1 = 4'd6,
    OP_INC2 = 4'd7,
    OP_DEC1 = 4'd8,
    OP_DEC2 = 4'd9,
    OP_AND  = 4'd10,
    OP_OR   = 4'd11,
    OP_XOR  = 4'd12,
    OP_ANDF = 4'd13,
    OP_ORF  = 4'd14,
    OP_XORF = 4'd15
  } alu_op_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
    case (sz)
      2'd0:    return {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      2'd1:    return {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [SIZE_W-1:0] sz);
    case (sz)
      2'd0:    return v[BYTE_W-1];
      2'd1:    return v[HALF_W-1];
      default: return v[DATA_W-1];
    endcase
  endfunction

  function automatic logic carry_at(input logic [DATA_W:0] v, input logic [SIZE_W-1:0] sz);
    case (sz)
      2'd0:    return v[BYTE_W];
      2'd1:    return v[HALF_W];
      default: return v[DATA_W];
    endcase
  endfunction
endpackage

// File: rtl/flagalu_arith.sv
module flagalu_arith
  import flagalu_pkg::*;
(
  input  alu_op_e             op,
  input  logic [SIZE_W-1:0]   size,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  input  logic                cin,
  output logic [DATA_W-1:0]   res,
  output logic [FLAG_W-1:0]   flags
);
  logic [SIZE_W-1:0] eff_sz;
  logic [DATA_W-1:0] mask, opa, opb;
  logic [DATA_W:0]   wide;
  logic              cy, sub, keep_c;
  logic              sa, sb, sr, cout, ovf;

  always_comb begin
    // carry-in operations are defined on bytes only
    eff_sz = (op == OP_ADDC || op == OP_SUBC) ? 2'd0 : size;
    mask   = size_mask(eff_sz);
    opa    = dst & mask;
    opb    = src & mask;
    cy     = 1'b0;
    sub    = 1'b0;
    keep_c = 1'b0;
    case (op)
      OP_ADDC: cy = cin;
      OP_SUB, OP_CMP: sub = 1'b1;
      OP_SUBC: begin sub = 1'b1; cy = cin; end
      OP_NEG: begin opa = '0; opb = dst & mask; sub = 1'b1; end
      OP_INC1: begin opb = {{(DATA_W-2){1'b0}}, 2'b01}; keep_c = 1'b1; end
      OP_INC2: begin opb = {{(DATA_W-2){1'b0}}, 2'b10}; keep_c = 1'b1; end
      OP_DEC1: begin opb = {{(DATA_W-2){1'b0}}, 2'b01}; sub = 1'b1; keep_c = 1'b1; end
      OP_DEC2: begin opb = {{(DATA_W-2){1'b0}}, 2'b10}; sub = 1'b1; keep_c = 1'b1; end
      default: ;
    endcase

    if (sub) wide = {1'b0, opa} - {1'b0, opb} - {{DATA_W{1'b0}}, cy};
    else     wide = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cy};

    res  = wide[DATA_W-1:0] & mask;
    sa   = top_bit(opa, eff_sz);
    sb   = top_bit(opb, eff_sz);
    sr   = top_bit(res, eff_sz);
    ovf  = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    // borrow fills every bit above the operands, so the top bit serves all sizes
    cout = sub ? wide[DATA_W] : carry_at(wide, eff_sz);

    flags        = '0;
    flags[FLG_N] = sr;
    flags[FLG_Z] = (res == '0);
    flags[FLG_V] = ovf;
    flags[FLG_C] = keep_c ? cin : cout;
  end
endmodule

// File: rtl/flagalu_logic.sv
module flagalu_logic
  import flagalu_pkg::*;
(
  input  alu_op_e             op,
  input  logic [SIZE_W-1:0]   size,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  input  logic [FLAG_W-1:0]   flags_in,
  output logic [DATA_W-1:0]   res,
  output logic [FLAG_W-1:0]   flags
);
  logic [DATA_W-1:0] mask, bits;
  logic [FLAG_W-1:0] imm, cc_new;
  logic              on_cc;

  always_comb begin
    mask = size_mask(size);
    imm  = src[FLAG_W-1:0];
    case (op)
      OP_OR:   bits = (dst | src) & mask;
      OP_XOR:  bits = (dst ^ src) & mask;
      default: bits = (dst & src) & mask;
    endcase
    case (op)
      OP_ORF:  cc_new = flags_in | imm;
      OP_XORF: cc_new = flags_in ^ imm;
      default: cc_new = flags_in & imm;
    endcase
    on_cc = (op == OP_ANDF) || (op == OP_ORF) || (op == OP_XORF);

    if (on_cc) begin
      res   = '0;
      flags = cc_new;
    end else begin
      res          = bits;
      flags        = '0;
      flags[FLG_N] = top_bit(bits, size);
      flags[FLG_Z] = (bits == '0);
      flags[FLG_V] = 1'b0;
      flags[FLG_C] = flags_in[FLG_C];
    end
  end
endmodule

// File: rtl/flagalu_stage.sv
module flagalu_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/flagalu.sv
module flagalu
  import flagalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_store,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int PAY_W = 1 + FLAG_W + DATA_W;

  alu_op_e           op;
  logic [DATA_W-1:0] a_res, l_res, sel_res;
  logic [FLAG_W-1:0] a_flg, l_flg, sel_flg;
  logic              logic_grp, wr_en;
  logic [PAY_W-1:0]  pay_in, pay_out;

  assign op = alu_op_e'(in_op);

  flagalu_arith u_arith (
    .op(op), .size(in_size), .dst(in_dst), .src(in_src),
    .cin(in_flags[FLG_C]), .res(a_res), .flags(a_flg)
  );

  flagalu_logic u_logic (
    .op(op), .size(in_size), .dst(in_dst), .src(in_src),
    .flags_in(in_flags), .res(l_res), .flags(l_flg)
  );

  always_comb begin
    logic_grp = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
                (op == OP_ANDF) || (op == OP_ORF) || (op == OP_XORF);
    wr_en     = !((op == OP_CMP) || (op == OP_ANDF) || (op == OP_ORF) || (op == OP_XORF));
    sel_res   = logic_grp ? l_res : a_res;
    sel_flg   = logic_grp ? l_flg : a_flg;
    pay_in    = {wr_en, sel_flg, sel_res};
  end

  flagalu_stage #(.PAY_W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(pay_in),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(pay_out)
  );

  assign out_result = pay_out[DATA_W-1:0];
  assign out_flags  = pay_out[DATA_W +: FLAG_W];
  assign out_store  = pay_out[PAY_W-1];
endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk
  import flagalu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [SIZE_W-1:0] in_size,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_store,
  input logic [FLAG_W-1:0] out_flags
);
  logic took;
  assign took = in_valid && in_ready;

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_flags) && $stable(out_store)));

  // R12
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);

  // R7
  cmp_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_op == OP_CMP) |=> !out_store);

  // R10
  logic_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR))
      |=> (!out_flags[FLG_V] && out_flags[FLG_C] == $past(in_flags[FLG_C])));

  // R9
  step_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (in_op == OP_INC1 || in_op == OP_INC2 || in_op == OP_DEC1 || in_op == OP_DEC2))
      |=> (out_flags[FLG_C] == $past(in_flags[FLG_C])));

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_store) |-> (out_flags[FLG_Z] == (out_result == '0)));

  // R2
  byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_size == 2'd0) |=> (out_result[DATA_W-1:BYTE_W] == '0));

  // R11
  ccop_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && (in_op == OP_ANDF || in_op == OP_ORF || in_op == OP_XORF))
      |=> (!out_store && out_result == '0));
endmodule

bind flagalu flagalu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_store(out_store), .out_flags(out_flags)
);

// File: tb/sim_flagalu.sv
`timescale 1ns/1ps
module sim_flagalu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_dst = '0;
  logic [31:0] in_src = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_store;
  logic [3:0]  out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flagalu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_dst(in_dst), .in_src(in_src),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_store(out_store), .out_flags(out_flags)
  );

  function automatic string req_of(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6, 7, 8, 9: return "R9";
      10, 11, 12: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic longint to_signed(input longint unsigned x, input int bits);
    if (x >= (64'd1 << (bits - 1))) return longint'(x) - longint'(64'd1 << bits);
    return longint'(x);
  endfunction

  // independent reference built on wide integers
  task automatic model(input int op, input int sz, input logic [31:0] d, input logic [31:0] s,
                       input logic [3:0] f, output logic [31:0] r, output logic st,
                       output logic [3:0] nf);
    int bits;
    longint unsigned mask, dm, sm, res, ci;
    longint sd, ss, exact, maxp, minn;
    logic n, z, v, c;
    bits = (op == 1 || op == 3) ? 8 : (sz == 0 ? 8 : (sz == 1 ? 16 : 32));
    mask = (64'd1 << bits) - 1;
    dm = d & mask; sm = s & mask; ci = f[0];
    sd = to_signed(dm, bits); ss = to_signed(sm, bits);
    maxp = longint'((64'd1 << (bits - 1)) - 1);
    minn = -longint'(64'd1 << (bits - 1));
    st = 1'b1; v = 1'b0; c = f[0]; res = 0; exact = 0;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        res = dm + sm + ci; exact = sd + ss + longint'(ci);
        c = (res >> bits) != 0; v = (exact > maxp) || (exact < minn);
      end
      2, 3, 4: begin
        if (op != 3) ci = 0;
        res = dm - sm - ci; exact = sd - ss - longint'(ci);
        c = dm < (sm + ci); v = (exact > maxp) || (exact < minn);
        if (op == 4) st = 1'b0;
      end
      5: begin
        res = 0 - dm; exact = -sd;
        c = dm != 0; v = (exact > maxp) || (exact < minn);
      end
      6, 7, 8, 9: begin
        longint k;
        k = (op == 6 || op == 8) ? 1 : 2;
        if (op <= 7) begin res = dm + longint'(k); exact = sd + k; end
        else begin res = dm - longint'(k); exact = sd - k; end
        v = (exact > maxp) || (exact < minn);
      end
      10: res = dm & sm;
      11: res = dm | sm;
      12: res = dm ^ sm;
      default: ;
    endcase
    res = res & mask;
    n = ((res >> (bits - 1)) & 1) != 0;
    z = (res == 0);
    r = res[31:0];
    nf = {n, z, v, c};
    if (op >= 13) begin
      st = 1'b0; r = '0;
      nf = (op == 13) ? (f & s[3:0]) : (op == 14) ? (f | s[3:0]) : (f ^ s[3:0]);
    end
  endtask

  task automatic run_op(input int op, input int sz, input logic [31:0] d,
                        input logic [31:0] s, input logic [3:0] f);
    logic [31:0] er; logic est; logic [3:0] ef;
    in_op = op[3:0]; in_size = sz[1:0]; in_dst = d; in_src = s; in_flags = f;
    in_valid = 1'b1;
    model(op, sz, d, s, f, er, est, ef);
    @(negedge clk);
    checks++;
    if (!out_valid || out_result !== er || out_store !== est || out_flags !== ef) begin
      errors++;
      $display("FAIL %s/R2 op=%0d size=%0d d=%h s=%h f=%b: got v=%b r=%h st=%b f=%b, expected v=1 r=%h st=%b f=%b",
               req_of(op), op, sz, d, s, f, out_valid, out_result, out_store, out_flags, er, est, ef);
    end
  endtask

  function automatic logic [31:0] edge_val(input int i, input int bits);
    logic [31:0] m, h;
    m = (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 1);
    h = 32'd1 << (bits - 1);
    case (i)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'd2;
      3: return h - 1;
      4: return h;
      5: return h + 1;
      6: return m;
      7: return m - 1;
      8: return 32'h5A3C_96E1 & m;
      default: return h - 2;
    endcase
  endfunction

  task automatic expect_bit(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  initial begin
    logic [7:0] bvals [12];
    logic [31:0] held_r;
    logic [3:0]  held_f;
    bvals = '{8'h00, 8'h01, 8'h02, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h0F};

    repeat (3) @(negedge clk);
    // R1: reset state
    expect_bit("R1", "out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bit("R1", "out_valid after reset", out_valid, 1'b0);
    expect_bit("R1", "in_ready after reset", in_ready, 1'b1);

    // byte sweep: every dst against boundary sources, dirty upper bits
    for (int op = 0; op < 16; op++)
      for (int d = 0; d < 256; d++)
        for (int j = 0; j < 12; j++) begin
          logic [3:0] f;
          f = 4'(d ^ (j * 5) ^ op);
          run_op(op, 0, {24'hC3A5E7, 8'(d)}, {24'h9D1B6F, bvals[j]}, f);
        end

    // 16- and 32-bit boundary sweep, both carry-in values
    for (int sz = 1; sz < 4; sz++)
      for (int op = 0; op < 16; op++)
        for (int a = 0; a < 10; a++)
          for (int b = 0; b < 10; b++)
            for (int cf = 0; cf < 2; cf++) begin
              int bits;
              bits = (sz == 1) ? 16 : 32;
              run_op(op, sz, edge_val(a, bits) | (sz == 1 ? 32'hBEEF_0000 : 32'h0),
                     edge_val(b, bits), cf ? 4'b1011 : 4'b0100);
            end

    // R12: stall keeps output, blocks input, then releases
    run_op(0, 0, 32'h0000_0012, 32'h0000_0034, 4'b0000);
    held_r = out_result; held_f = out_flags;
    out_ready = 1'b0;
    in_op = 4'd2; in_size = 2'd0; in_dst = 32'h10; in_src = 32'h20; in_flags = 4'b0000;
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      expect_bit("R12", "in_ready low while stalled", in_ready, 1'b0);
      checks++;
      if (!out_valid || out_result !== held_r || out_flags !== held_f) begin
        errors++;
        $display("FAIL R12 stalled output: got v=%b r=%h f=%b expected v=1 r=%h f=%b",
                 out_valid, out_result, out_flags, held_r, held_f);
      end
    end
    out_ready = 1'b1;
    #1;
    expect_bit("R12", "in_ready when downstream ready", in_ready, 1'b1);
    @(negedge clk);
    checks++;
    if (!out_valid || out_result !== 32'h0000_00F0 || out_flags !== 4'b1001) begin
      errors++;
      $display("FAIL R12 released item: got v=%b r=%h f=%b expected v=1 r=000000f0 f=1001",
               out_valid, out_result, out_flags);
    end
    in_valid = 1'b0;
    @(negedge clk);
    expect_bit("R12", "out_valid drains", out_valid, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected run to finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule